// File: doc/BRIEF.md
# Low-Frequency Oscillator Failover Monitor

This block watches an external low-frequency clock that arrives asynchronously. It runs on the clock of an internal low-frequency oscillator and treats that clock as the safe source. The external clock passes through a synchronizer, and its rising edges are timed against a safe tick. The safe tick runs at the internal oscillator rate, or at half that rate, depending on a control bit. If the safe tick reaches a fixed count with no external edge, the block declares a failure. It then moves the clock-source select to the safe clock and latches a sticky failure flag.

Once the external clock is back and has delivered a run of edges that are each on time, the block counts it as recovered. If the switch-back enable is set, the select returns to the external clock and the hardware clears the switch-back enable. If the switch-back enable is clear, the select stays on the safe clock until software sets the enable.

Software talks to the block over a simple single-cycle register bus. It reaches a control register, which has a write lock, and a status register whose failure flag is cleared by writing a one.

Top module: `osc_failover`

## Requirements
- R1: After reset, the control word at address 0 reads 0, the status word at address 1 reads 0, and the source select is 0 (external clock). In the control word, bit 0 is the monitor enable, bit 1 is the switch-back enable and bit 2 is the half-rate select. All higher control bits read 0. In the status word, bit 0 is the sticky failure flag and bit 1 is the live source select.
- R2: While the monitor enable is 0, no failure is flagged and the source select stays 0, even if the external clock is stopped.
- R3: The safe tick is high on every cycle when bit 2 is 0. When bit 2 is 1, it is high on every second cycle.
- R4: A control write sets the switch-back enable only if the stored monitor enable is already 1 and the written monitor enable is also 1. Any other control write leaves the switch-back enable at 0.
- R5: With monitoring on, a failure is declared when TIMEOUT safe ticks (default 4) pass without an external rising edge. The source select then goes to 1 and the sticky flag is set.
- R6: After a failure, the external clock counts as recovered after RECOVER consecutive on-time rising edges (default 8). If the switch-back enable is 1 at that point, the source select returns to 0.
- R7: The switch-back enable is cleared by hardware on the same edge that returns the source select to the external clock.
- R8: While the lock input is 1, writes to the control register are discarded.
- R9: Writing 1 to status bit 0 clears the sticky flag, and writing 0 leaves it unchanged. If a new failure arrives in the same cycle as the clear, the flag stays set.
- R10: If the switch-back enable is 0 when recovery is seen, the source select stays 1. A later write that sets the switch-back enable returns the select to 0.
- R11: Clearing the monitor enable while failed over returns the source select to 0. It also restarts the edge timing, so re-enabling with a stopped clock does not fail before TIMEOUT new ticks.
- R12: An external clock whose rising-edge spacing always leaves fewer than TIMEOUT safe ticks between edges never causes a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock (safe domain) |
| rst | input | 1 | Synchronous active-high reset |
| ext_clk | input | 1 | Monitored external clock, asynchronous |
| lock | input | 1 | Write protection for the control register |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 control, 1 status) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data, combinational from bus_addr |
| safe_tick | output | 1 | Safe-clock enable strobe |
| clk_src_safe | output | 1 | Source select: 1 = safe clock, 0 = external clock |
| fail_sticky | output | 1 | Sticky failure flag |

## Verification
A rising edge on `ext_clk` reaches the edge detector two clock edges later. At the default settings, the source select rises N+2 cycles after the first clock edge that samples the final external rise. For that reason, the failure-spacing sweep waits 60 cycles per spacing before it samples, and it skips the one half-rate spacing whose outcome depends on tick phase. Register writes land on the clock edge inside the write task. A hardware switch-back caused by a new enable write shows one edge later, so those checks wait two cycles. Every sample is taken at the falling edge, or one time unit after it.

// File: rtl/osc_fo_pkg.sv
package osc_fo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WATCH  = 2'd1,
        ST_FAILED = 2'd2,
        ST_HELD   = 2'd3
    } fo_state_t;

    // packed: en is bit 0, swback bit 1, half bit 2
    typedef struct packed {
        logic half;
        logic swback;
        logic en;
    } fo_ctrl_t;

    localparam int unsigned ADDR_CTRL = 0;
    localparam int unsigned ADDR_STAT = 1;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

    function automatic logic on_safe(input fo_state_t s);
        return (s == ST_FAILED) || (s == ST_HELD);
    endfunction

endpackage

// File: rtl/osc_fo_edge_sync.sv
module osc_fo_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], async_in};
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

endmodule

// File: rtl/osc_fo_tick.sv
module osc_fo_tick (
    input  logic clk,
    input  logic rst,
    input  logic half,
    output logic tick
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
        end else if (!half) begin
            phase <= 1'b0;
        end else begin
            phase <= ~phase;
        end
    end

    assign tick = ~half | phase;

    a_r3_half_rate: assert property (@(posedge clk) disable iff (rst)
        (half && $past(half) && tick) |=> (!tick || !half));

endmodule

// File: rtl/osc_fo_monitor.sv
module osc_fo_monitor
    import osc_fo_pkg::*;
#(
    parameter int unsigned TIMEOUT = 4,
    parameter int unsigned RECOVER = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic swback,
    input  logic edge_seen,
    input  logic tick,
    output logic use_safe,
    output logic fail_evt,
    output logic back_done
);
    localparam int unsigned GW = cnt_bits(TIMEOUT);
    localparam int unsigned RW = cnt_bits(RECOVER);
    localparam logic [GW-1:0] GAP_LAST  = GW'(TIMEOUT - 1);
    localparam logic [RW-1:0] GOOD_LAST = RW'(RECOVER - 1);

    fo_state_t      state, state_n;
    logic [GW-1:0]  gap_cnt, gap_n;
    logic [RW-1:0]  good_cnt, good_n;
    logic           timeout;

    assign timeout = tick && !edge_seen && (gap_cnt == GAP_LAST);

    always_comb begin
        if (!en || edge_seen) begin
            gap_n = '0;
        end else if (tick && gap_cnt != GAP_LAST) begin
            gap_n = gap_cnt + 1'b1;
        end else begin
            gap_n = gap_cnt;
        end
    end

    always_comb begin
        state_n   = state;
        good_n    = good_cnt;
        fail_evt  = 1'b0;
        back_done = 1'b0;
        if (!en) begin
            state_n = ST_IDLE;
            good_n  = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    state_n = ST_WATCH;
                    good_n  = '0;
                end
                ST_WATCH: begin
                    good_n = '0;
                    if (timeout) begin
                        state_n  = ST_FAILED;
                        fail_evt = 1'b1;
                    end
                end
                ST_FAILED: begin
                    if (timeout) begin
                        good_n = '0;
                    end else if (edge_seen) begin
                        if (good_cnt == GOOD_LAST) begin
                            good_n = '0;
                            if (swback) begin
                                state_n   = ST_WATCH;
                                back_done = 1'b1;
                            end else begin
                                state_n = ST_HELD;
                            end
                        end else begin
                            good_n = good_cnt + 1'b1;
                        end
                    end
                end
                ST_HELD: begin
                    good_n = '0;
                    if (timeout) begin
                        state_n  = ST_FAILED;
                        fail_evt = 1'b1;
                    end else if (swback) begin
                        state_n   = ST_WATCH;
                        back_done = 1'b1;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            gap_cnt  <= '0;
            good_cnt <= '0;
        end else begin
            state    <= state_n;
            gap_cnt  <= gap_n;
            good_cnt <= good_n;
        end
    end

    assign use_safe = on_safe(state);

    a_r2_idle_on_ext: assert property (@(posedge clk) disable iff (rst)
        !en |=> !use_safe);

    a_r5_fail_goes_safe: assert property (@(posedge clk) disable iff (rst)
        fail_evt |=> use_safe);

    a_r6_return_needs_swback: assert property (@(posedge clk) disable iff (rst)
        $fell(use_safe) |-> ($past(swback) || !$past(en)));

endmodule

// File: rtl/osc_fo_regs.sv
module osc_fo_regs
    import osc_fo_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              lock,
    input  logic              fail_evt,
    input  logic              back_done,
    input  logic              use_safe,
    output fo_ctrl_t          ctrl,
    output logic              fail_sticky,
    output logic [DATA_W-1:0] bus_rdata
);
    logic hit_ctrl, hit_stat, ctrl_wr;

    assign hit_ctrl = (bus_addr == ADDR_W'(ADDR_CTRL));
    assign hit_stat = (bus_addr == ADDR_W'(ADDR_STAT));
    assign ctrl_wr  = bus_wr && hit_ctrl && !lock;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.en     <= bus_wdata[0];
                ctrl.half   <= bus_wdata[2];
                ctrl.swback <= bus_wdata[1] && bus_wdata[0] && ctrl.en;
            end
            if (back_done) begin
                ctrl.swback <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_sticky <= 1'b0;
        end else if (fail_evt) begin
            fail_sticky <= 1'b1;
        end else if (bus_wr && hit_stat && bus_wdata[0]) begin
            fail_sticky <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctrl) begin
            bus_rdata[2:0] = ctrl;
        end else if (hit_stat) begin
            bus_rdata[0] = fail_sticky;
            bus_rdata[1] = use_safe;
        end
    end

    a_r4_swback_needs_en: assert property (@(posedge clk) disable iff (rst)
        ctrl.swback |-> ctrl.en);

    a_r8_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && lock && hit_ctrl) |=> ($stable(ctrl.en) && $stable(ctrl.half)));

    a_r9_sticky_set: assert property (@(posedge clk) disable iff (rst)
        fail_evt |=> fail_sticky);

    a_r7_swback_cleared: assert property (@(posedge clk) disable iff (rst)
        $fell(use_safe) |-> !ctrl.swback);

endmodule

// File: rtl/osc_failover.sv
module osc_failover
    import osc_fo_pkg::*;
#(
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned TIMEOUT     = 4,
    parameter int unsigned RECOVER     = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_clk,
    input  logic              lock,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              safe_tick,
    output logic              clk_src_safe,
    output logic              fail_sticky
);
    fo_ctrl_t ctrl;
    logic     ext_rise, fail_evt, back_done, use_safe;

    osc_fo_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_clk),
        .rise     (ext_rise)
    );

    osc_fo_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .half (ctrl.half),
        .tick (safe_tick)
    );

    osc_fo_monitor #(.TIMEOUT(TIMEOUT), .RECOVER(RECOVER)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.en),
        .swback    (ctrl.swback),
        .edge_seen (ext_rise),
        .tick      (safe_tick),
        .use_safe  (use_safe),
        .fail_evt  (fail_evt),
        .back_done (back_done)
    );

    osc_fo_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .lock        (lock),
        .fail_evt    (fail_evt),
        .back_done   (back_done),
        .use_safe    (use_safe),
        .ctrl        (ctrl),
        .fail_sticky (fail_sticky),
        .bus_rdata   (bus_rdata)
    );

    assign clk_src_safe = use_safe;

endmodule

// File: tb/sim_osc_failover.sv
`timescale 1ns/1ps
module sim_osc_failover;
    localparam int DW = 32;
    localparam int AW = 2;
    localparam int N  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_clk = 1'b0;
    logic          lock = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          safe_tick, clk_src_safe, fail_sticky;

    int checks = 0;
    int errors = 0;
    int ext_per = 0;
    bit done = 0;

    always #2 clk = ~clk;

    osc_failover u0 (
        .clk(clk), .rst(rst), .ext_clk(ext_clk), .lock(lock),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .safe_tick(safe_tick),
        .clk_src_safe(clk_src_safe), .fail_sticky(fail_sticky)
    );

    // external clock generator: period ext_per cycles, 0 = stopped low
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (ext_per == 0) begin
                ext_clk = 1'b0;
                cnt = 0;
            end else begin
                ext_clk = (cnt < (ext_per + 1) / 2);
                cnt = (cnt + 1 >= ext_per) ? 0 : cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        int tcount;
        bit skip;
        bit exp_fail;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, d); check("R1 ctrl reset", d, 0);
        rd(1, d); check("R1 stat reset", d, 0);
        check("R1 src reset", DW'(clk_src_safe), 0);

        // R2 disabled monitor ignores stopped clock
        cycles(100);
        check("R2 no fail when disabled", DW'(fail_sticky), 0);
        check("R2 src stays ext", DW'(clk_src_safe), 0);

        // R4 swback rules
        wr(0, 32'h2); rd(0, d); check("R4 swback needs en", d, 0);
        ext_per = 3; cycles(6);
        wr(0, 32'h3); rd(0, d); check("R4 same-write en", d, 32'h1);
        wr(0, 32'h3); rd(0, d); check("R4 swback set", d, 32'h3);
        wr(0, 32'h2); rd(0, d); check("R4 en cleared drops swback", d, 32'h0);
        // R1 reserved bits read zero
        wr(0, 32'h1);
        wr(0, 32'hFFFF_FFFF); rd(0, d); check("R1 reserved zero", d, 32'h7);
        wr(0, 32'h0);

        // R8 lock
        lock = 1'b1;
        wr(0, 32'h5); rd(0, d); check("R8 locked write dropped", d, 0);
        lock = 1'b0;

        // R3 tick rates
        wr(0, 32'h0); cycles(2);
        tcount = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); tcount += int'(safe_tick); end
        check("R3 full rate", DW'(tcount), 20);
        wr(0, 32'h4); cycles(2);
        tcount = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); tcount += int'(safe_tick); end
        check("R3 half rate", DW'(tcount), 10);

        // R5 / R12 sweep over spacing and rate
        for (int h = 0; h < 2; h++) begin
            for (int p = 2; p <= 12; p++) begin
                skip = (h == 1) && (p == 2 * N);
                if (!skip) begin
                    wr(0, 32'h0); wr(1, 32'h1);
                    ext_per = p; cycles(2 * p);
                    wr(0, (h == 1) ? 32'h5 : 32'h1);
                    cycles(60);
                    exp_fail = (h == 0) ? (p - 1 >= N) : ((p - 1) / 2 >= N);
                    if (exp_fail) check("R5 gap fails", DW'(fail_sticky), 1);
                    else          check("R12 on-time never fails", DW'(fail_sticky), 0);
                    check("R5 src follows fail", DW'(clk_src_safe), DW'(exp_fail));
                end
            end
        end

        // R9 W1C
        wr(0, 32'h0); ext_per = 0; wr(1, 32'h1);
        wr(0, 32'h1); cycles(30);
        rd(1, d); check("R5 status fail+safe", d, 32'h3);
        wr(1, 32'h0); rd(1, d); check("R9 write zero keeps", d[0], 1);
        wr(1, 32'h1); rd(1, d); check("R9 w1c clears", d[0], 0);

        // R6 / R7 switch back
        wr(0, 32'h0); ext_per = 3; cycles(6);
        wr(0, 32'h1); wr(0, 32'h3);
        ext_per = 0; cycles(30);
        check("R5 failed over", DW'(clk_src_safe), 1);
        ext_per = 3; cycles(10);
        check("R6 not yet recovered", DW'(clk_src_safe), 1);
        cycles(40);
        check("R6 switched back", DW'(clk_src_safe), 0);
        rd(0, d); check("R7 swback self-clear", d, 32'h1);

        // R10 held on safe without swback
        ext_per = 0; cycles(30);
        check("R10 failed again", DW'(clk_src_safe), 1);
        ext_per = 3; cycles(60);
        check("R10 held on safe", DW'(clk_src_safe), 1);
        wr(0, 32'h3); cycles(2);
        check("R10 return after enable", DW'(clk_src_safe), 0);
        rd(0, d); check("R7 cleared after late return", d, 32'h1);

        // R11 disable while failed
        ext_per = 0; cycles(30);
        check("R11 failed", DW'(clk_src_safe), 1);
        wr(0, 32'h0); cycles(2);
        check("R11 disable returns ext", DW'(clk_src_safe), 0);
        wr(1, 32'h1);
        wr(0, 32'h1); #1;
        check("R11 counters restarted", DW'(fail_sticky), 0);
        cycles(10);
        check("R11 later fails", DW'(fail_sticky), 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule